// File: doc/BRIEF.md
# Record Source Selector with Copy Gating

This block picks where the samples of the record stream come from and shapes them into the format the host asked for. One candidate source is a digital audio receiver that hands over decoded stereo frames together with a lock flag, a sample-rate code, a format-ok flag and a copy-generation code. The other is the ADC sample path, which always runs at the rate the host selected. The ADC frame strobe paces the block. Each ADC frame strobe produces one output frame for the record FIFO, one cycle later.

The digital frame is used only when every one of these holds: the receiver is locked, it reports 16-bit stereo at one of the three rates it supports, the copy code marks the material as original, the host rate equals the received rate, and the host asks for at most one reduction. In every other case the ADC frame is used. The choice is made once per frame, at the ADC strobe, and applies to the whole left/right pair. After the source is chosen, the block applies the requested reductions: mono averaging and/or narrowing to 8 bits. Both reductions together are only possible on the ADC path.

Top module: `rec_src_sel`

## Requirements
- R1: For each cycle with `adc_valid` high, `rec_valid` is high in the following cycle. `rec_valid` is low in every other cycle.
- R2: An output frame carries the most recently captured receiver frame, with `rec_from_rx` = 1, when all of the following hold at the strobe: `rx_lock` = 1, `rx_fmt_ok` = 1, `rx_copy_gen` = 0, the rate codes match, at most one reduction is requested, and a receiver frame has been captured since lock was gained. The rate codes match when `rx_rate` is 1 (32 kHz) with `host_rate` 4, `rx_rate` 2 (44.1 kHz) with `host_rate` 5, or `rx_rate` 3 (48 kHz) with `host_rate` 6.
- R3: With `rx_lock` = 0 at the strobe, the frame comes from the ADC inputs and `rec_from_rx` = 0.
- R4: With `rx_copy_gen` nonzero (first generation or later) at the strobe, the frame comes from the ADC inputs.
- R5: A rate-code mismatch while locked selects the ADC inputs and sets `rec_fmt_mismatch` = 1 for that frame. `rx_rate` = 0 means unsupported and never matches. `rec_fmt_mismatch` = 0 when the lock is absent, or when the rates match and at most one reduction is requested.
- R6: With `host_mono` = 1 and `host_narrow` = 1 while locked, the frame comes from the ADC inputs and `rec_fmt_mismatch` = 1.
- R7: With `host_mono` = 1, both output channels equal floor((L + R + 1) / 2), where L and R are the two's-complement inputs of the selected source.
- R8: With `host_narrow` = 1, each output channel equals floor((x + 128) / 256), saturated to the range -128..127 and sign-extended to 16 bits.
- R9: With both reductions on the ADC path, the mono mean is formed first and then narrowed per R8.
- R10: When `rx_lock` falls, the captured receiver frame is discarded. After lock returns, the ADC inputs stay selected until a new receiver frame has been captured.
- R11: After reset, `rec_valid`, `rec_left`, `rec_right`, `rec_from_rx` and `rec_fmt_mismatch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_valid | input | 1 | ADC stereo frame strobe (frame boundary) |
| adc_left | input | 16 | ADC left sample, two's complement |
| adc_right | input | 16 | ADC right sample, two's complement |
| rx_valid | input | 1 | Receiver stereo frame strobe |
| rx_left | input | 16 | Receiver left sample |
| rx_right | input | 16 | Receiver right sample |
| rx_lock | input | 1 | Receiver locked on valid data |
| rx_fmt_ok | input | 1 | Receiver reports 16-bit stereo |
| rx_rate | input | 2 | Received rate: 0 none, 1 32k, 2 44.1k, 3 48k |
| rx_copy_gen | input | 2 | Copy generation: 0 original, else copy |
| host_rate | input | 3 | Host rate: 0 8k,1 11.025k,2 16k,3 22.05k,4 32k,5 44.1k,6 48k |
| host_mono | input | 1 | Host requests mono |
| host_narrow | input | 1 | Host requests 8-bit samples |
| rec_valid | output | 1 | Output frame strobe |
| rec_left | output | 16 | Formatted left (or mono) sample |
| rec_right | output | 16 | Formatted right (or mono) sample |
| rec_from_rx | output | 1 | Frame came from the receiver |
| rec_fmt_mismatch | output | 1 | Locked receiver rejected for format |

## Verification
The bench targets the rounding edges of both reductions. A mean of 1 and 0 must round up to 1, while a mean of -1 and 0 must round to 0; a truncating design would give 0 and -1. A full-scale positive sample must saturate to 127 instead of wrapping to -128. The bench also loses and regains lock without sending a fresh receiver frame: a design that keeps the stale frame would put old digital data into the record stream. Finally, the bench requests both reductions and a rate that differs from the received rate. In both cases a design that trusts the lock alone would forward receiver data and leave the mismatch flag clear.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    RX_NONE = 2'd0, RX_32K = 2'd1, RX_44K1 = 2'd2, RX_48K = 2'd3
  } rx_rate_e;

  localparam logic [2:0] HOST_RATE_OFS = 3'd3;

  function automatic logic rates_agree(input logic [1:0] rx, input logic [2:0] host);
    return (rx != RX_NONE) && (host == ({1'b0, rx} + HOST_RATE_OFS));
  endfunction
endpackage

// File: rtl/rss_rx_hold.sv
module rss_rx_hold #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          in_valid,
  input  logic [SW-1:0] in_l,
  input  logic [SW-1:0] in_r,
  output logic [SW-1:0] held_l,
  output logic [SW-1:0] held_r,
  output logic          held_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_l  <= '0;
      held_r  <= '0;
      held_ok <= 1'b0;
    end else if (!lock) begin
      held_ok <= 1'b0;
    end else if (in_valid) begin
      held_l  <= in_l;
      held_r  <= in_r;
      held_ok <= 1'b1;
    end
  end

  AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !held_ok); // R10
endmodule

// File: rtl/rss_qualify.sv
module rss_qualify (
  input  logic       lock,
  input  logic       fmt_ok,
  input  logic [1:0] rx_rate,
  input  logic [1:0] copy_gen,
  input  logic [2:0] host_rate,
  input  logic       want_mono,
  input  logic       want_narrow,
  input  logic       held_ok,
  output logic       use_rx,
  output logic       mismatch
);
  import rss_pkg::*;
  logic is_original;
  logic double_reduce;

  always_comb begin
    is_original   = (copy_gen == 2'd0);
    double_reduce = want_mono && want_narrow;
    mismatch      = lock && (!rates_agree(rx_rate, host_rate) || double_reduce);
    use_rx        = lock && fmt_ok && is_original && !mismatch && held_ok;
  end
endmodule

// File: rtl/rss_reduce.sv
module rss_reduce #(
  parameter int SW = 16,
  parameter int NW = 8
) (
  input  logic [SW-1:0] in_l,
  input  logic [SW-1:0] in_r,
  input  logic          want_mono,
  input  logic          want_narrow,
  output logic [SW-1:0] out_l,
  output logic [SW-1:0] out_r
);
  localparam int SHIFT = SW - NW;
  localparam logic [SW:0] HALF_LSB = (SW+1)'(1) << (SHIFT - 1);

  function automatic logic [SW-1:0] mean2(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW:0] s;
    s = {a[SW-1], a} + {b[SW-1], b} + (SW+1)'(1);
    return s[SW:1];
  endfunction

  function automatic logic [SW-1:0] narrow(input logic [SW-1:0] x);
    logic [SW:0] t;
    logic [NW:0] q;
    logic [NW-1:0] n;
    t = {x[SW-1], x} + HALF_LSB;
    q = t[SW:SHIFT];
    if (!q[NW] && q[NW-1]) n = {1'b0, {(NW-1){1'b1}}};
    else                   n = q[NW-1:0];
    return {{SHIFT{n[NW-1]}}, n};
  endfunction

  logic [SW-1:0] avg, a_l, a_r;

  always_comb begin
    avg   = mean2(in_l, in_r);
    a_l   = want_mono ? avg : in_l;
    a_r   = want_mono ? avg : in_r;
    out_l = want_narrow ? narrow(a_l) : a_l;
    out_r = want_narrow ? narrow(a_r) : a_r;
  end
endmodule

// File: rtl/rec_src_sel.sv
module rec_src_sel #(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adc_valid,
  input  logic [SAMPLE_W-1:0] adc_left,
  input  logic [SAMPLE_W-1:0] adc_right,
  input  logic                rx_valid,
  input  logic [SAMPLE_W-1:0] rx_left,
  input  logic [SAMPLE_W-1:0] rx_right,
  input  logic                rx_lock,
  input  logic                rx_fmt_ok,
  input  logic [1:0]          rx_rate,
  input  logic [1:0]          rx_copy_gen,
  input  logic [2:0]          host_rate,
  input  logic                host_mono,
  input  logic                host_narrow,
  output logic                rec_valid,
  output logic [SAMPLE_W-1:0] rec_left,
  output logic [SAMPLE_W-1:0] rec_right,
  output logic                rec_from_rx,
  output logic                rec_fmt_mismatch
);
  localparam int EXT_HI = SAMPLE_W - 1;
  localparam int EXT_LO = NARROW_W - 1;

  logic [SAMPLE_W-1:0] held_l, held_r, pick_l, pick_r, fmt_l, fmt_r;
  logic held_ok, use_rx, mismatch, frame_tick;

  assign frame_tick = adc_valid;

  rss_rx_hold #(.SW(SAMPLE_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .lock(rx_lock), .in_valid(rx_valid),
    .in_l(rx_left), .in_r(rx_right),
    .held_l(held_l), .held_r(held_r), .held_ok(held_ok)
  );

  rss_qualify qual_i (
    .lock(rx_lock), .fmt_ok(rx_fmt_ok), .rx_rate(rx_rate), .copy_gen(rx_copy_gen),
    .host_rate(host_rate), .want_mono(host_mono), .want_narrow(host_narrow),
    .held_ok(held_ok), .use_rx(use_rx), .mismatch(mismatch)
  );

  assign pick_l = use_rx ? held_l : adc_left;
  assign pick_r = use_rx ? held_r : adc_right;

  rss_reduce #(.SW(SAMPLE_W), .NW(NARROW_W)) red_i (
    .in_l(pick_l), .in_r(pick_r), .want_mono(host_mono), .want_narrow(host_narrow),
    .out_l(fmt_l), .out_r(fmt_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid        <= 1'b0;
      rec_left         <= '0;
      rec_right        <= '0;
      rec_from_rx      <= 1'b0;
      rec_fmt_mismatch <= 1'b0;
    end else begin
      rec_valid <= frame_tick;
      if (frame_tick) begin
        rec_left         <= fmt_l;
        rec_right        <= fmt_r;
        rec_from_rx      <= use_rx;
        rec_fmt_mismatch <= mismatch;
      end
    end
  end

  AST_FRAME_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |=> rec_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_valid |=> !rec_valid); // R1
  AST_UNLOCKED_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && !rx_lock |=> !rec_from_rx); // R3
  AST_COPY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && (rx_copy_gen != 2'd0) |=> !rec_from_rx); // R4
  AST_MISMATCH_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_fmt_mismatch |-> !rec_from_rx); // R5
  AST_BOTH_REDUCE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && rx_lock && host_mono && host_narrow |=> rec_fmt_mismatch && !rec_from_rx); // R6
  AST_MONO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && host_mono |=> rec_left == rec_right); // R7
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid && host_narrow |=> (rec_left[EXT_HI:EXT_LO] == '0) || (&rec_left[EXT_HI:EXT_LO])); // R8
endmodule

// File: tb/rec_src_sel_tb_top.sv
module rec_src_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_valid = 1'b0, rx_valid = 1'b0;
  logic [15:0] adc_left = '0, adc_right = '0, rx_left = '0, rx_right = '0;
  logic rx_lock = 1'b0, rx_fmt_ok = 1'b0, host_mono = 1'b0, host_narrow = 1'b0;
  logic [1:0] rx_rate = 2'd0, rx_copy_gen = 2'd0;
  logic [2:0] host_rate = 3'd6;
  logic rec_valid, rec_from_rx, rec_fmt_mismatch;
  logic [15:0] rec_left, rec_right;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rec_src_sel dut_i (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_left(adc_left), .adc_right(adc_right),
    .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right), .rx_lock(rx_lock),
    .rx_fmt_ok(rx_fmt_ok), .rx_rate(rx_rate), .rx_copy_gen(rx_copy_gen), .host_rate(host_rate),
    .host_mono(host_mono), .host_narrow(host_narrow), .rec_valid(rec_valid),
    .rec_left(rec_left), .rec_right(rec_right), .rec_from_rx(rec_from_rx),
    .rec_fmt_mismatch(rec_fmt_mismatch)
  );

  function automatic int fdiv(input int n, input int d);
    int q;
    q = n / d;
    if ((n % d != 0) && (n < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int m_mean(input int a, input int b);
    return fdiv(a + b + 1, 2);
  endfunction

  function automatic int m_narrow(input int x);
    int v;
    v = fdiv(x + 128, 256);
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_rx(input int l, input int r);
    @(negedge clk);
    rx_left = 16'(l); rx_right = 16'(r); rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_adc(input int l, input int r);
    @(negedge clk);
    adc_left = 16'(l); adc_right = 16'(r); adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic set_rx(input logic lock, input logic [1:0] rate, input logic [1:0] copy);
    @(negedge clk);
    rx_lock = lock; rx_fmt_ok = 1'b1; rx_rate = rate; rx_copy_gen = copy;
  endtask

  task automatic t_reset;
    chk("R11 valid", int'(rec_valid), 0);
    chk("R11 left", int'(rec_left), 0);
    chk("R11 src", int'(rec_from_rx), 0);
    chk("R11 mismatch", int'(rec_fmt_mismatch), 0);
  endtask

  task automatic t_adc_unlocked;
    set_rx(1'b0, 2'd3, 2'd0);
    host_mono = 0; host_narrow = 0; host_rate = 3'd6;
    send_adc(1234, -567);
    chk("R1 valid", int'(rec_valid), 1);
    chk("R3 left", int'($signed(rec_left)), 1234);
    chk("R3 right", int'($signed(rec_right)), -567);
    chk("R3 src", int'(rec_from_rx), 0);
    chk("R5 no flag unlocked", int'(rec_fmt_mismatch), 0);
    @(negedge clk);
    chk("R1 no spurious", int'(rec_valid), 0);
  endtask

  task automatic t_rx_selected;
    set_rx(1'b1, 2'd3, 2'd0);
    host_rate = 3'd6;
    send_rx(-1000, 2000);
    send_adc(11, 22);
    chk("R2 src", int'(rec_from_rx), 1);
    chk("R2 left", int'($signed(rec_left)), -1000);
    chk("R2 right", int'($signed(rec_right)), 2000);
    chk("R5 flag clear", int'(rec_fmt_mismatch), 0);
  endtask

  task automatic t_copy_gate;
    set_rx(1'b1, 2'd3, 2'd1);
    send_adc(77, 88);
    chk("R4 src", int'(rec_from_rx), 0);
    chk("R4 left", int'($signed(rec_left)), 77);
    set_rx(1'b1, 2'd3, 2'd0);
  endtask

  task automatic t_rate_mismatch;
    host_rate = 3'd5;
    send_adc(5, 6);
    chk("R5 src", int'(rec_from_rx), 0);
    chk("R5 flag", int'(rec_fmt_mismatch), 1);
    chk("R5 left", int'($signed(rec_left)), 5);
    set_rx(1'b1, 2'd2, 2'd0);
    send_rx(300, 400);
    send_adc(1, 2);
    chk("R2 44k1 src", int'(rec_from_rx), 1);
    chk("R2 44k1 left", int'($signed(rec_left)), 300);
    set_rx(1'b1, 2'd0, 2'd0);
    send_adc(9, 9);
    chk("R5 unsupported flag", int'(rec_fmt_mismatch), 1);
    chk("R5 unsupported src", int'(rec_from_rx), 0);
  endtask

  task automatic t_both_reductions;
    set_rx(1'b1, 2'd3, 2'd0);
    host_rate = 3'd6; host_mono = 1; host_narrow = 1;
    send_rx(100, 100);
    send_adc(1000, 3000);
    chk("R6 src", int'(rec_from_rx), 0);
    chk("R6 flag", int'(rec_fmt_mismatch), 1);
    chk("R9 left", int'($signed(rec_left)), m_narrow(m_mean(1000, 3000)));
    chk("R9 right", int'($signed(rec_right)), m_narrow(m_mean(1000, 3000)));
    host_mono = 0; host_narrow = 0;
  endtask

  task automatic t_mono;
    host_mono = 1;
    send_rx(101, -50);
    send_adc(0, 0);
    chk("R7 rx src", int'(rec_from_rx), 1);
    chk("R7 rx mean", int'($signed(rec_left)), m_mean(101, -50));
    set_rx(1'b0, 2'd3, 2'd0);
    send_adc(1, 0);
    chk("R7 half up", int'($signed(rec_left)), 1);
    send_adc(-1, 0);
    chk("R7 neg half", int'($signed(rec_right)), 0);
    send_adc(32767, 32767);
    chk("R7 pos max", int'($signed(rec_left)), 32767);
    send_adc(-32768, -32768);
    chk("R7 neg max", int'($signed(rec_left)), -32768);
    host_mono = 0;
  endtask

  task automatic t_narrow;
    set_rx(1'b1, 2'd3, 2'd0);
    host_narrow = 1;
    send_rx(32767, -32768);
    send_adc(0, 0);
    chk("R8 rx src", int'(rec_from_rx), 1);
    chk("R8 saturate", int'($signed(rec_left)), 127);
    chk("R8 neg full", int'($signed(rec_right)), -128);
    set_rx(1'b0, 2'd3, 2'd0);
    send_adc(128, 127);
    chk("R8 round up", int'($signed(rec_left)), m_narrow(128));
    chk("R8 round down", int'($signed(rec_right)), 0);
    send_adc(-129, -385);
    chk("R8 neg left", int'($signed(rec_left)), m_narrow(-129));
    chk("R8 neg right", int'($signed(rec_right)), m_narrow(-385));
    host_narrow = 0;
  endtask

  task automatic t_lock_loss;
    set_rx(1'b1, 2'd3, 2'd0);
    send_rx(4444, 5555);
    send_adc(1, 1);
    chk("R10 before loss", int'(rec_from_rx), 1);
    set_rx(1'b0, 2'd3, 2'd0);
    send_adc(2, 3);
    chk("R10 after loss src", int'(rec_from_rx), 0);
    chk("R10 after loss left", int'($signed(rec_left)), 2);
    set_rx(1'b1, 2'd3, 2'd0);
    send_adc(6, 7);
    chk("R10 stale discarded", int'(rec_from_rx), 0);
    chk("R10 stale left", int'($signed(rec_left)), 6);
    send_rx(-9, 9);
    send_adc(0, 0);
    chk("R10 fresh src", int'(rec_from_rx), 1);
    chk("R10 fresh left", int'($signed(rec_left)), -9);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_adc_unlocked();
    t_rx_selected();
    t_copy_gate();
    t_rate_mismatch();
    t_both_reductions();
    t_mono();
    t_narrow();
    t_lock_loss();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule